// File: doc/BRIEF.md
# Signed Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a filter engine. Each step takes a 16-bit coefficient and a 16-bit sample, both in two's complement, and multiplies them into a 32-bit product register. In the same step, the product left by the previous step is added into a 32-bit accumulator. A multiplicand register keeps the sample used by the latest multiply. A buffer register can take a copy of the accumulator so that a partial result can be kept while the next sum is built.

A second multiply-accumulate command also shifts the sample delay line. Its sample comes from data address d. One cycle later the block raises a single-cycle write request that puts the same word at address d+1. A loop of these commands therefore runs an FIR tap sequence and moves the sample history along in one pass. An overflow flag records any accumulator addition that left the signed 32-bit range. When the saturation mode input is high, the accumulator clamps to its largest or smallest value instead of wrapping.

Top module: `mac_unit`

## Requirements
- R1: After reset, the accumulator, buffer, multiplicand, overflow flag, write strobe, write address and write data all read zero.
- R2: A multiply step (cmd_i 1 or 2) loads the product register with the signed 32-bit product of dm_word_i and pm_word_i. The product shows in acc_o through the next accumulating command.
- R3: Commands 1, 2 and 3 (3 = add product only, product kept) set the accumulator to the accumulator plus the product register as it stood before the edge, wrapping modulo 2^32 when sat_mode_i is 0.
- R4: ovf_o goes to 1 when an accumulating addition leaves the signed 32-bit range. It stays at 1 until command 6 clears it.
- R5: With sat_mode_i at 1, an overflowing addition leaves 0x7FFFFFFF when the true sum is positive and 0x80000000 when it is negative.
- R6: Command 2 raises wr_en_o for exactly the cycle after the accepting edge, with wr_addr_o equal to dm_addr_i+1 (modulo 2^16) and wr_data_o equal to dm_word_i.
- R7: Every command other than 2 leaves wr_en_o at 0 in the following cycle.
- R8: Command 4 copies the accumulator into acc_buf_o. No other command changes acc_buf_o.
- R9: Command 5 zeroes the accumulator and the product register at the same edge and leaves ovf_o unchanged.
- R10: Command 0 and command 7 change no observable state.
- R11: Commands 1 and 2 load mcand_o with dm_word_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code for this cycle |
| sat_mode_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| pm_word_i | input | 16 | Coefficient operand (signed) |
| dm_word_i | input | 16 | Sample operand (signed) |
| dm_addr_i | input | 16 | Address of the sample operand |
| acc_o | output | 32 | Accumulator |
| acc_buf_o | output | 32 | Accumulator buffer |
| ovf_o | output | 1 | Sticky overflow flag |
| mcand_o | output | 16 | Multiplicand register |
| wr_en_o | output | 1 | Delay-line write strobe |
| wr_addr_o | output | 16 | Delay-line write address |
| wr_data_o | output | 16 | Delay-line write data |

## Verification
Every visible result is registered, so each one appears in the cycle that follows the edge that accepts the command: accumulator, buffer, flag, multiplicand and the delay-line write fields alike. The product behaves differently. It only becomes visible through the accumulator, one accumulating command after the multiply that made it, so the reference model carries a product term forward, and an add-only command exposes it. The bench drives each command at a falling edge and advances its model at the rising edge. It compares all outputs at the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_MAC   = 3'd1,
        CMD_MACD  = 3'd2,
        CMD_ADDP  = 3'd3,
        CMD_SAVE  = 3'd4,
        CMD_CLR   = 3'd5,
        CMD_CLROV = 3'd6,
        CMD_RSVD  = 3'd7
    } mac_cmd_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic signed [PW-1:0] p_o
);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    always_comb begin
        a_ext = PW'(a_i);
        b_ext = PW'(b_i);
        p_o   = a_ext * b_ext;
    end

endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sat_en_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;

    always_comb begin
        raw   = a_i + b_i;
        ovf_o = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        if (ovf_o && sat_en_i) begin
            sum_o = a_i[W-1] ? NEG_LIMIT : POS_LIMIT;
        end else begin
            sum_o = raw;
        end
    end

    // R5: a clamped result carries the sign of the operands
    always_comb begin
        if (ovf_o && sat_en_i) begin
            assert_clamp_R5: assert (sum_o == (b_i[W-1] ? NEG_LIMIT : POS_LIMIT));
        end
    end

endmodule

// File: rtl/mac_move.sv
module mac_move #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fire_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } move_t;

    move_t mv_d, mv_q;

    always_comb begin
        mv_d    = mv_q;
        mv_d.en = fire_i;
        if (fire_i) begin
            mv_d.addr = addr_i + AW'(1);
            mv_d.data = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mv_q <= '0;
        end else begin
            mv_q <= mv_d;
        end
    end

    assign wr_en_o   = mv_q.en;
    assign wr_addr_o = mv_q.addr;
    assign wr_data_o = mv_q.data;

    // R6: strobe is a single cycle unless a new move is accepted
    assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && wr_en_o && !fire_i) |=> !wr_en_o);

    // R6: target is the next address
    assert_next_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && fire_i) |=> (wr_en_o && wr_addr_o == $past(addr_i) + AW'(1)));

    // R7: no strobe without an accepted move
    assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && !fire_i) |=> !wr_en_o);

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        cmd_i,
    input  logic              sat_mode_i,
    input  logic [DW-1:0]     pm_word_i,
    input  logic [DW-1:0]     dm_word_i,
    input  logic [AW-1:0]     dm_addr_i,
    output logic [2*DW-1:0]   acc_o,
    output logic [2*DW-1:0]   acc_buf_o,
    output logic              ovf_o,
    output logic [DW-1:0]     mcand_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DW-1:0]     wr_data_o
);

    import mac_pkg::*;

    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [PW-1:0] acc;
        logic [PW-1:0] abuf;
        logic [PW-1:0] prod;
        logic [DW-1:0] mcand;
        logic          ovf;
    } core_t;

    core_t     st_d, st_q;
    mac_cmd_e  cmd;
    logic [PW-1:0] mul_res;
    logic [PW-1:0] add_res;
    logic          add_ovf;
    logic          do_mul;
    logic          do_acc;
    logic          do_move;

    assign cmd = mac_cmd_e'(cmd_i);

    mac_mult #(.DW(DW)) u_mult (
        .a_i (dm_word_i),
        .b_i (pm_word_i),
        .p_o (mul_res)
    );

    mac_sat_add #(.W(PW)) u_add (
        .a_i      (st_q.acc),
        .b_i      (st_q.prod),
        .sat_en_i (sat_mode_i),
        .sum_o    (add_res),
        .ovf_o    (add_ovf)
    );

    mac_move #(.DW(DW), .AW(AW)) u_move (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (do_move),
        .addr_i    (dm_addr_i),
        .data_i    (dm_word_i),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    always_comb begin
        do_mul  = (cmd == CMD_MAC) || (cmd == CMD_MACD);
        do_acc  = do_mul || (cmd == CMD_ADDP);
        do_move = (cmd == CMD_MACD);

        st_d = st_q;
        if (do_acc) begin
            st_d.acc = add_res;
            if (add_ovf) begin
                st_d.ovf = 1'b1;
            end
        end
        if (do_mul) begin
            st_d.prod  = mul_res;
            st_d.mcand = dm_word_i;
        end
        case (cmd)
            CMD_SAVE:  st_d.abuf = st_q.acc;
            CMD_CLR: begin
                st_d.acc  = '0;
                st_d.prod = '0;
            end
            CMD_CLROV: st_d.ovf = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o     = st_q.acc;
    assign acc_buf_o = st_q.abuf;
    assign ovf_o     = st_q.ovf;
    assign mcand_o   = st_q.mcand;

    // R4: the flag holds until the clear command
    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && ovf_o && cmd_i != 3'd6) |=> ovf_o);

    // R9: clear empties the accumulator
    assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && cmd_i == 3'd5) |=> (acc_o == '0));

    // R8: buffer moves only on save
    assert_buf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && cmd_i != 3'd4) |=> $stable(acc_buf_o));

    // R10: idle codes freeze the accumulator
    assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && (cmd_i == 3'd0 || cmd_i == 3'd7)) |=> ($stable(acc_o) && $stable(mcand_o)));

    // R11: multiplicand follows the sample of a multiply step
    assert_mcand_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && (cmd_i == 3'd1 || cmd_i == 3'd2)) |=> (mcand_o == $past(dm_word_i)));

endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam longint MAXV = 64'sd2147483647;
    localparam longint MINV = -64'sd2147483648;
    localparam longint MOD32 = 64'sd4294967296;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        sat = 1'b0;
    logic [15:0] pm = '0;
    logic [15:0] dm = '0;
    logic [15:0] addr = '0;
    logic [31:0] acc, abuf;
    logic        ovf, we;
    logic [15:0] mcand, wa, wd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    longint m_acc = 0, m_buf = 0, m_prod = 0;
    int     m_t = 0, m_wa = 0, m_wd = 0;
    bit     m_ovf = 0, m_we = 0;
    string  acc_tag = "R1";
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .sat_mode_i(sat),
        .pm_word_i(pm), .dm_word_i(dm), .dm_addr_i(addr),
        .acc_o(acc), .acc_buf_o(abuf), .ovf_o(ovf), .mcand_o(mcand),
        .wr_en_o(we), .wr_addr_o(wa), .wr_data_o(wd)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk(acc_tag, "acc", acc, 32'(m_acc));
        chk("R4", "ovf", 32'(ovf), 32'(m_ovf));
        chk("R8", "buf", abuf, 32'(m_buf));
        chk(m_we ? "R6" : "R7", "wr_en", 32'(we), 32'(m_we));
        chk("R6", "wr_addr", 32'(wa), 32'(m_wa));
        chk("R6", "wr_data", 32'(wd), 32'(m_wd));
        chk("R11", "mcand", 32'(mcand), 32'(m_t & 16'hFFFF));
    endtask

    task automatic model_accum(input bit s);
        longint sum;
        sum = m_acc + m_prod;
        if (sum > MAXV || sum < MINV) begin
            m_ovf = 1;
            if (s) begin
                sum = (sum > 0) ? MAXV : MINV;
                acc_tag = "R5";
            end else begin
                sum = (sum > 0) ? sum - MOD32 : sum + MOD32;
            end
        end
        m_acc = sum;
    endtask

    task automatic step(input int c, input int d, input int p, input int a, input bit s);
        cmd = 3'(c); dm = 16'(d); pm = 16'(p); addr = 16'(a); sat = s;
        @(posedge clk);
        m_we = 0;
        acc_tag = "R3";
        case (c)
            1, 2: begin
                model_accum(s);
                m_t = d;
                m_prod = longint'(d) * longint'(p);
                if (c == 2) begin
                    m_we = 1;
                    m_wa = (a + 1) % 65536;
                    m_wd = d & 16'hFFFF;
                end
            end
            3: begin
                acc_tag = "R2";
                model_accum(s);
            end
            4: m_buf = m_acc;
            5: begin m_acc = 0; m_prod = 0; acc_tag = "R9"; end
            6: m_ovf = 0;
            default: acc_tag = "R10";
        endcase
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        acc_tag = "R1";
        compare_all();
        // R2 R3 R11: basic products and accumulation
        step(1, 3, 4, 5, 0);
        step(1, -5, 7, 6, 0);
        step(3, 0, 0, 0, 0);
        step(3, 0, 0, 0, 0);
        // R6: delay-line move, then R7 quiet cycle
        step(2, 16'h1234, 2, 16'h0010, 0);
        step(0, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0);
        step(2, -1, -1, 16'hFFFF, 0);
        step(2, 100, -3, 16'h0020, 0);
        // R4: wrap overflow with sticky flag
        step(5, 0, 0, 0, 0);
        step(1, -32768, -32768, 0, 0);
        step(3, 0, 0, 0, 0);
        step(3, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0);
        step(6, 0, 0, 0, 0);
        // R5: positive saturation
        step(5, 0, 0, 0, 1);
        step(1, -32768, -32768, 0, 1);
        step(3, 0, 0, 0, 1);
        step(3, 0, 0, 0, 1);
        step(3, 0, 0, 0, 1);
        step(6, 0, 0, 0, 1);
        // R5: negative saturation
        step(5, 0, 0, 0, 1);
        step(1, -32768, 32767, 0, 1);
        step(3, 0, 0, 0, 1);
        step(3, 0, 0, 0, 1);
        step(3, 0, 0, 0, 1);
        // R9: clear keeps flag; R10: reserved code ignored
        step(5, 0, 0, 0, 0);
        step(7, 77, 88, 99, 0);
        step(0, 11, 22, 33, 1);
        // mixed pattern
        for (int i = 0; i < 60; i++) begin
            int c;
            seed = seed * 32'd1103515245 + 32'd12345;
            c = int'(seed[30:28]);
            step(c, int'($signed(seed[15:0])), int'($signed(seed[27:12])), int'(seed[23:8]), seed[31]);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule